// File: doc/BRIEF.md
# Double-Buffered Frame Flip Controller

This block decides which of two frame buffers a continuously refreshing display replays. The refresh sequencer plays the active buffer from start to end over and over. At each end of frame it continues with whichever buffer the controller names as the loop target. A writer fills the other buffer and then asks for a flip, naming the buffer it wants shown.

A flip never switches the picture in the middle of a frame. The request only changes where the frame continues after its end. The new buffer becomes active at the next end-of-frame event. A request also clears a flag that tells the writer whether the buffer shown before is free to be overwritten. That flag is set again when the next end-of-frame event arrives, because the display has by then moved to the requested buffer.

The writer switches its back-buffer id after each flip. The block drives that id, always the buffer opposite the pending loop target. The asynchronous reset is released through a short synchronizer, so internal state leaves reset a few clock edges after `rst_n` rises.

Top module: `frame_flip_ctl`

## Requirements
- R1: While reset is held and after it is released with no other stimulus, `active_id` is 0, `loop_id` is 0, `wr_id` is 1 and `prev_free` is 1.
- R2: When `frame_end` is low, `active_id` keeps its value. When `frame_end` pulses with no flip requested since the last boundary, `active_id` is unchanged, because the buffer loops to its own start.
- R3: A cycle with `flip_req` high loads `flip_id` into `loop_id` at that clock edge. `active_id` does not change because of the request alone.
- R4: A cycle with `frame_end` high makes `active_id` equal, after that edge, to the `loop_id` value held before the edge.
- R5: A cycle with `flip_req` high makes `prev_free` 0 after that edge.
- R6: A cycle with `frame_end` high and `flip_req` low makes `prev_free` 1 after that edge. With both inputs low, `prev_free` holds its value.
- R7: When `flip_req` and `frame_end` are high in the same cycle, the frame boundary uses the old `loop_id`. The new id is loaded for the following boundary, and `prev_free` ends at 0.
- R8: A flip naming the buffer that is already active leaves `active_id` unchanged across the next boundary. It still clears `prev_free`, which is set again at that boundary.
- R9: `wr_id` is always the inverse of `loop_id`, so after each flip the writer's back buffer alternates.
- R10: Several flip requests before one boundary resolve to the last one. `prev_free` stays 0 for any number of cycles until a boundary occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flip_req | input | 1 | One-cycle request to show the buffer named by `flip_id` |
| flip_id | input | 1 | Buffer to show after the next frame boundary (0 or 1) |
| frame_end | input | 1 | One-cycle end-of-frame event from the refresh sequencer |
| active_id | output | 1 | Buffer currently being replayed |
| loop_id | output | 1 | Buffer the refresh continues with after the current frame |
| wr_id | output | 1 | Buffer the writer should fill next |
| prev_free | output | 1 | 1 when the previously shown buffer may be written |

## Verification
The directed scenarios target the mistakes that would change the picture at the wrong moment. One such design switches `active_id` on the request itself and would tear the frame mid-scan. Another lets a request that collides with `frame_end` take effect at that same boundary. A third drops the flag clear when the flip names the buffer already active, and the writer would then overwrite a buffer while it is on screen. The bench also checks a burst of requests before one boundary, where a design keeping the first request would show the wrong buffer. A long wait with no boundary would expose a flag that sets itself early.

// File: rtl/flipctl_pkg.sv
package flipctl_pkg;
  localparam int ID_W = 1;
  typedef logic [ID_W-1:0] buf_id_t;
  localparam buf_id_t RESET_BUF = '0;
endpackage

// File: rtl/flipctl_rst_sync.sv
module flipctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/flipctl_loop_target.sv
module flipctl_loop_target
  import flipctl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req,
  input  buf_id_t req_id,
  output buf_id_t target
);
  buf_id_t target_q, target_d;
  logic    target_ce;

  always_comb begin
    target_ce = req;
    target_d  = req_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         target_q <= RESET_BUF;
    else if (target_ce) target_q <= target_d;
  end

  assign target = target_q;

  // R3: a request loads the requested id
  p_target_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> target == $past(req_id));
  // R10: no request means the pending target holds
  p_target_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> $stable(target));
endmodule

// File: rtl/flipctl_active_track.sv
module flipctl_active_track
  import flipctl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    frame_end,
  input  buf_id_t target,
  output buf_id_t active
);
  buf_id_t active_q, active_d;
  logic    active_ce;

  always_comb begin
    active_ce = frame_end;
    active_d  = target;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         active_q <= RESET_BUF;
    else if (active_ce) active_q <= active_d;
  end

  assign active = active_q;

  // R2: no boundary, no change of displayed buffer
  p_active_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(active));
  // R4: a boundary adopts the target held before the edge
  p_active_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> active == $past(target));
endmodule

// File: rtl/flipctl_free_flag.sv
module flipctl_free_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic frame_end,
  output logic free
);
  logic free_q, free_d, free_ce;

  always_comb begin
    free_ce = req | frame_end;
    // a request outranks a boundary in the same cycle
    free_d  = !req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       free_q <= 1'b1;
    else if (free_ce) free_q <= free_d;
  end

  assign free = free_q;

  // R5: a request clears the flag
  p_free_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !free);
  // R6: a boundary without a request sets the flag
  p_free_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !req) |=> free);
  // R10: quiet cycles keep the flag
  p_free_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end && !req) |=> $stable(free));
endmodule

// File: rtl/frame_flip_ctl.sv
module frame_flip_ctl
  import flipctl_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flip_req,
  input  logic flip_id,
  input  logic frame_end,
  output logic active_id,
  output logic loop_id,
  output logic wr_id,
  output logic prev_free
);
  logic    rst_n_s;
  buf_id_t target;
  buf_id_t active;
  logic    free;

  flipctl_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  flipctl_loop_target u_tgt (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .req    (flip_req),
    .req_id (flip_id),
    .target (target)
  );

  flipctl_active_track u_act (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .frame_end (frame_end),
    .target    (target),
    .active    (active)
  );

  flipctl_free_flag u_free (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .req       (flip_req),
    .frame_end (frame_end),
    .free      (free)
  );

  assign active_id = active;
  assign loop_id   = target;
  assign wr_id     = ~target;
  assign prev_free = free;

  // R9: after a flip the writer is pointed at the other buffer
  p_wr_alt_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    flip_req |=> wr_id != $past(flip_id));
  // R7: a colliding request does not reach the current boundary
  p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (flip_req && frame_end) |=> (active_id == $past(loop_id)) && !prev_free);
endmodule

// File: tb/sim_frame_flip_ctl.sv
module sim_frame_flip_ctl;
  logic clk = 1'b0;
  logic rst_n;
  logic flip_req, flip_id, frame_end;
  logic active_id, loop_id, wr_id, prev_free;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  frame_flip_ctl u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .flip_req  (flip_req),
    .flip_id   (flip_id),
    .frame_end (frame_end),
    .active_id (active_id),
    .loop_id   (loop_id),
    .wr_id     (wr_id),
    .prev_free (prev_free)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  // inputs applied after a falling edge, results read at the next falling edge
  task automatic step(input logic rq, input logic id, input logic fe);
    flip_req  = rq;
    flip_id   = id;
    frame_end = fe;
    @(negedge clk);
    flip_req  = 1'b0;
    flip_id   = 1'b0;
    frame_end = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "active in reset", active_id, 1'b0);
    chk("R1", "free in reset", prev_free, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "active", active_id, 1'b0);
    chk("R1", "loop", loop_id, 1'b0);
    chk("R1", "wr", wr_id, 1'b1);
    chk("R1", "free", prev_free, 1'b1);
  endtask

  task automatic t_loop;
    step(0, 0, 1);
    chk("R2", "self loop active", active_id, 1'b0);
    chk("R6", "free after boundary", prev_free, 1'b1);
  endtask

  task automatic t_flip;
    step(1, 1, 0);
    chk("R3", "loop loaded", loop_id, 1'b1);
    chk("R3", "active held", active_id, 1'b0);
    chk("R5", "free cleared", prev_free, 1'b0);
    chk("R9", "wr alternates", wr_id, 1'b0);
    for (int i = 0; i < 5; i++) step(0, 0, 0);
    chk("R10", "free stays low", prev_free, 1'b0);
    chk("R2", "no boundary no switch", active_id, 1'b0);
    step(0, 0, 1);
    chk("R4", "switch at boundary", active_id, 1'b1);
    chk("R6", "free set", prev_free, 1'b1);
  endtask

  task automatic t_same;
    step(1, 1, 0);
    chk("R8", "free cleared same id", prev_free, 1'b0);
    step(0, 0, 1);
    chk("R8", "active unchanged", active_id, 1'b1);
    chk("R8", "free set again", prev_free, 1'b1);
  endtask

  task automatic t_collide;
    step(1, 0, 1);
    chk("R7", "boundary used old target", active_id, 1'b1);
    chk("R7", "new target loaded", loop_id, 1'b0);
    chk("R7", "free low", prev_free, 1'b0);
    step(0, 0, 1);
    chk("R7", "switch next boundary", active_id, 1'b0);
    chk("R7", "free set", prev_free, 1'b1);
  endtask

  task automatic t_burst;
    step(1, 1, 0);
    step(1, 0, 0);
    chk("R9", "wr after last", wr_id, 1'b1);
    step(0, 0, 1);
    chk("R10", "last request wins", active_id, 1'b0);
    step(1, 1, 0);
    step(0, 0, 1);
    chk("R4", "second switch", active_id, 1'b1);
    chk("R9", "wr back to 0", wr_id, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0;
    flip_req = 1'b0;
    flip_id = 1'b0;
    frame_end = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_loop();
    t_flip();
    t_same();
    t_collide();
    t_burst();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule